// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block holds the loose control registers that sit beside a workstation I/O controller: a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary bytes, a 16-bit LED word and a system-control word. A host reaches them over a plain synchronous register bus. The bus has one select line per register, a small offset field, 32-bit write data and a write strobe. Reads return the selected register zero-extended to 32 bits, without delay.

Several register writes act on the rest of the system. A bit in the first auxiliary byte sends a one-cycle terminal-count pulse to a floppy controller. The second auxiliary byte carries a power-off command and a write-one-to-clear power-fail status; together with an enable bit in the configuration byte, that status drives the power-fail interrupt. A command bit in the system-control word latches a reset-status flag and asks for a system reset. The block's reset clears only part of the register set. The diagnostic byte, the LED word and the system-control flag survive reset, so software can inspect them after a restart.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `pwr_irq_o` is high exactly when the stored power-fail status (second auxiliary byte, bit 5) and the stored power-interrupt enable (configuration byte, bit 3) are both set.
- R2: When `pwr_fail_i` differs from its value in the previous cycle, the power-fail status is loaded with `pwr_fail_i` AND the enable bit. While the input is steady, only R5 changes the status.
- R3: A write to the first auxiliary byte (select bit 5) stores every bit except bit 1, which reads 0. If bit 1 of the written data is set, `tc_pulse_o` is high for exactly the one cycle after the write edge.
- R4: A write to the second auxiliary byte (select bit 6) takes only bit 0 from the data. Bits 7:6 and 4:1 read 0, and bit 5 keeps its value unless R5 applies.
- R5: A second-auxiliary write with data bit 1 set clears the power-fail status, so the byte reads back as the written bit 0 alone.
- R6: A second-auxiliary write with data bit 0 set makes `pwroff_req_o` high for the one cycle after the write edge. The stored bit 0 reads back as written.
- R7: A write to the system-control word (select bit 4) at offset 0 with data bit 0 set makes the word read 0x00000002 and makes `sysrst_req_o` high for the one cycle after the write edge. Writes at other offsets, or with bit 0 clear, change nothing and request nothing.
- R8: Reset clears the configuration (select bit 0), modem-control (select bit 2) and both auxiliary bytes. The diagnostic byte (select bit 1), the LED word and the system-control flag keep their values through reset.
- R9: The configuration, diagnostic and modem-control bytes store data bits 7:0 unchanged. The LED word (select bit 3) stores bits 15:0 at offset 0. All reads are zero-extended to 32 bits.
- R10: Reads of LED or system-control offsets other than 0 return zero, and LED writes at those offsets are ignored.
- R11: Reads have no side effect. A cycle without a write strobe is followed by a cycle with all three request pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 7 | One-hot register select: 0 cfg, 1 diag, 2 modem, 3 LED, 4 sysctl, 5 aux1, 6 aux2 |
| reg_ofs | input | 2 | Offset within the LED and system-control regions |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| pwr_fail_i | input | 1 | Power-failing indication |
| pwr_irq_o | output | 1 | Power-fail interrupt |
| tc_pulse_o | output | 1 | Terminal-count pulse to floppy controller |
| pwroff_req_o | output | 1 | Power-off request pulse |
| sysrst_req_o | output | 1 | System-reset request pulse |

## Verification
A wrong power-fail status shows up on `pwr_irq_o` and in the second auxiliary readback in the cycle after the input edge or the clearing write. A wrong store mask shows up on the very next read of the register. A pulse that is missing, stretched or repeated shows up on the request outputs within two cycles of the write edge. A register that is wiped or kept wrongly by reset is exposed by reading the whole register set right after reset is released.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  localparam int NSEL     = 7;
  localparam int SEL_CFG  = 0;
  localparam int SEL_DIAG = 1;
  localparam int SEL_MDM  = 2;
  localparam int SEL_LED  = 3;
  localparam int SEL_SYS  = 4;
  localparam int SEL_AUX1 = 5;
  localparam int SEL_AUX2 = 6;

  localparam int CFG_PIE_BIT  = 3;
  localparam int AUX1_TC_BIT  = 1;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_PF_BIT  = 5;
  localparam int SYS_CMD_BIT  = 0;
  localparam int SYS_STAT_BIT = 1;
endpackage

// File: rtl/aux_rst_sync.sv
module aux_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb chain_nxt = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/aux_reg.sv
module aux_reg #(
  parameter int           W         = 8,
  parameter bit           SPARE     = 1'b0,
  parameter logic [W-1:0] KEEP_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb q_nxt = we ? (d & KEEP_MASK) : q;

  generate
    if (SPARE) begin : g_spare
      always_ff @(posedge clk) begin
        q <= q_nxt;
      end
    end else begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/aux_pwr_ctrl.sv
module aux_pwr_ctrl
  import aux_sysctl_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_i,
  input  logic              pie_i,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wd_i,
  output logic [BYTE_W-1:0] stat_o,
  output logic              pwroff_o
);
  logic pf_q, pf_nxt;
  logic pf_stat, pf_stat_nxt;
  logic off_bit, off_bit_nxt;
  logic off_pls, off_pls_nxt;
  logic pf_chg;

  always_comb begin
    pf_chg      = pf_i ^ pf_q;
    pf_nxt      = pf_i;
    pf_stat_nxt = pf_stat;
    if (we_i && wd_i[AUX2_CLR_BIT]) pf_stat_nxt = 1'b0;
    if (pf_chg)                     pf_stat_nxt = pf_i & pie_i;
    off_bit_nxt = we_i ? wd_i[AUX2_OFF_BIT] : off_bit;
    off_pls_nxt = we_i & wd_i[AUX2_OFF_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q    <= 1'b0;
      pf_stat <= 1'b0;
      off_bit <= 1'b0;
      off_pls <= 1'b0;
    end else begin
      pf_q    <= pf_nxt;
      pf_stat <= pf_stat_nxt;
      off_bit <= off_bit_nxt;
      off_pls <= off_pls_nxt;
    end
  end

  always_comb begin
    stat_o               = '0;
    stat_o[AUX2_PF_BIT]  = pf_stat;
    stat_o[AUX2_OFF_BIT] = off_bit;
  end

  assign pwroff_o = off_pls;

  assert_pf_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_chg |=> (pf_stat == $past(pf_i && pie_i)));

  assert_pf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wd_i[AUX2_CLR_BIT] && !pf_chg) |=> !pf_stat);

  assert_off_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwroff_o |-> off_bit);
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int LED_W  = 16,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSEL-1:0]   reg_sel,
  input  logic [OFS_W-1:0]  reg_ofs,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pwr_fail_i,
  output logic              pwr_irq_o,
  output logic              tc_pulse_o,
  output logic              pwroff_req_o,
  output logic              sysrst_req_o
);
  localparam logic [BYTE_W-1:0] AUX1_MASK = ~(BYTE_W'(1) << AUX1_TC_BIT);

  logic rst_s_n;
  logic [NSEL-1:0] we;
  logic ofs_zero, led_we, sys_we;
  logic [BYTE_W-1:0] cfg_q, diag_q, mdm_q, aux1_q, aux2_q;
  logic [LED_W-1:0]  led_q;
  logic              sys_flag_q;
  logic tc_q, tc_nxt, rst_req_q, rst_req_nxt;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:LED_W];

  aux_rst_sync #(.STAGES(2)) u_rsync (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  always_comb begin
    for (int i = 0; i < NSEL; i++) we[i] = wr_en & reg_sel[i];
    ofs_zero = (reg_ofs == '0);
    led_we   = we[SEL_LED] & ofs_zero;
    sys_we   = we[SEL_SYS] & ofs_zero & wdata[SYS_CMD_BIT];
    tc_nxt      = we[SEL_AUX1] & wdata[AUX1_TC_BIT];
    rst_req_nxt = sys_we;
  end

  aux_reg #(.W(BYTE_W), .SPARE(1'b0)) u_cfg (.clk(clk), .rst_n(rst_s_n),
    .we(we[SEL_CFG]), .d(wdata[BYTE_W-1:0]), .q(cfg_q));
  aux_reg #(.W(BYTE_W), .SPARE(1'b1)) u_diag (.clk(clk), .rst_n(rst_s_n),
    .we(we[SEL_DIAG]), .d(wdata[BYTE_W-1:0]), .q(diag_q));
  aux_reg #(.W(BYTE_W), .SPARE(1'b0)) u_mdm (.clk(clk), .rst_n(rst_s_n),
    .we(we[SEL_MDM]), .d(wdata[BYTE_W-1:0]), .q(mdm_q));
  aux_reg #(.W(BYTE_W), .SPARE(1'b0), .KEEP_MASK(AUX1_MASK)) u_aux1 (.clk(clk),
    .rst_n(rst_s_n), .we(we[SEL_AUX1]), .d(wdata[BYTE_W-1:0]), .q(aux1_q));
  aux_reg #(.W(LED_W), .SPARE(1'b1)) u_led (.clk(clk), .rst_n(rst_s_n),
    .we(led_we), .d(wdata[LED_W-1:0]), .q(led_q));
  aux_reg #(.W(1), .SPARE(1'b1)) u_sysflag (.clk(clk), .rst_n(rst_s_n),
    .we(sys_we), .d(1'b1), .q(sys_flag_q));

  aux_pwr_ctrl #(.BYTE_W(BYTE_W)) u_pwr (
    .clk(clk), .rst_n(rst_s_n), .pf_i(pwr_fail_i), .pie_i(cfg_q[CFG_PIE_BIT]),
    .we_i(we[SEL_AUX2]), .wd_i(wdata[BYTE_W-1:0]), .stat_o(aux2_q),
    .pwroff_o(pwroff_req_o));

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tc_q      <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      tc_q      <= tc_nxt;
      rst_req_q <= rst_req_nxt;
    end
  end

  assign tc_pulse_o   = tc_q;
  assign sysrst_req_o = rst_req_q;
  assign pwr_irq_o    = aux2_q[AUX2_PF_BIT] & cfg_q[CFG_PIE_BIT];

  always_comb begin
    rdata = '0;
    if (reg_sel[SEL_CFG])  rdata[BYTE_W-1:0] = rdata[BYTE_W-1:0] | cfg_q;
    if (reg_sel[SEL_DIAG]) rdata[BYTE_W-1:0] = rdata[BYTE_W-1:0] | diag_q;
    if (reg_sel[SEL_MDM])  rdata[BYTE_W-1:0] = rdata[BYTE_W-1:0] | mdm_q;
    if (reg_sel[SEL_AUX1]) rdata[BYTE_W-1:0] = rdata[BYTE_W-1:0] | aux1_q;
    if (reg_sel[SEL_AUX2]) rdata[BYTE_W-1:0] = rdata[BYTE_W-1:0] | aux2_q;
    if (reg_sel[SEL_LED] && ofs_zero) rdata[LED_W-1:0] = rdata[LED_W-1:0] | led_q;
    if (reg_sel[SEL_SYS] && ofs_zero) rdata[SYS_STAT_BIT] = rdata[SYS_STAT_BIT] | sys_flag_q;
  end

  assert_tc_cause_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    tc_pulse_o |-> $past(wr_en && reg_sel[SEL_AUX1] && wdata[AUX1_TC_BIT]));

  assert_tc_not_stored_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !aux1_q[AUX1_TC_BIT]);

  assert_rst_flag_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    sysrst_req_o |-> sys_flag_q);

  assert_quiet_read_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_en |=> !(tc_pulse_o || pwroff_req_o || sysrst_req_o));
endmodule

// File: tb/sim_aux_sysctl_regs.sv
`timescale 1ns/1ps
module sim_aux_sysctl_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  reg_sel;
  logic [1:0]  reg_ofs;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        pwr_fail_i;
  logic        pwr_irq_o, tc_pulse_o, pwroff_req_o, sysrst_req_o;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  aux_sysctl_regs u0 (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_ofs(reg_ofs),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .pwr_fail_i(pwr_fail_i),
    .pwr_irq_o(pwr_irq_o), .tc_pulse_o(tc_pulse_o), .pwroff_req_o(pwroff_req_o),
    .sysrst_req_o(sysrst_req_o));

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] pulses();
    return {sysrst_req_o, pwroff_req_o, tc_pulse_o};
  endfunction

  task automatic wr(input int s, input logic [1:0] o, input logic [31:0] d,
                    output logic [2:0] p1, output logic [2:0] p2);
    @(negedge clk);
    reg_sel = 7'(1 << s); reg_ofs = o; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 p1 = pulses();
    @(negedge clk);
    wr_en = 1'b0; reg_sel = '0;
    @(posedge clk); #1 p2 = pulses();
  endtask

  task automatic rd(input int s, input logic [1:0] o, input logic [31:0] exp,
                    input string tag);
    @(negedge clk);
    reg_sel = 7'(1 << s); reg_ofs = o; wr_en = 1'b0;
    #1;
    chk(rdata === exp, tag, rdata, exp);
    chk(pulses() === 3'b000, "R11 pulses during read", 32'(pulses()), 0);
  endtask

  task automatic set_pf(input logic v);
    @(negedge clk); pwr_fail_i = v;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] p1, p2;
    reg_sel = '0; reg_ofs = '0; wr_en = 1'b0; wdata = '0; pwr_fail_i = 1'b0;
    rst_n = 1'b0;
    do_reset();

    // R8: cleared registers after reset
    rd(0, 0, 0, "R8 cfg reset");
    rd(2, 0, 0, "R8 modem reset");
    rd(5, 0, 0, "R8 aux1 reset");
    rd(6, 0, 0, "R8 aux2 reset");
    chk(pwr_irq_o === 1'b0, "R1 irq after reset", 32'(pwr_irq_o), 0);

    // R9 / R1: byte register sweeps
    for (int v = 0; v < 256; v++) begin
      for (int s = 0; s < 3; s++) begin
        wr(s, 0, 32'hFFFF_FF00 | 32'(v), p1, p2);
        chk({p1, p2} === 6'b0, "R9 no pulses", 32'({p1, p2}), 0);
        rd(s, 0, 32'(v), "R9 byte readback");
      end
      chk(pwr_irq_o === 1'b0, "R1 irq needs status", 32'(pwr_irq_o), 0);
    end
    wr(0, 0, 0, p1, p2);

    // R3: aux1 sweep
    for (int v = 0; v < 256; v++) begin
      wr(5, 0, 32'(v), p1, p2);
      chk(p1[0] === v[1], "R3 tc pulse", 32'(p1[0]), 32'(v[1]));
      chk(p2 === 3'b000, "R3 tc single cycle", 32'(p2), 0);
      rd(5, 0, 32'(v & 8'hFD), "R3 aux1 readback");
    end

    // R4 / R6: aux2 sweep with status clear
    for (int v = 0; v < 256; v++) begin
      wr(6, 0, 32'(v), p1, p2);
      chk(p1 === {1'b0, v[0], 1'b0}, "R6 pwroff pulse", 32'(p1), 32'({v[0], 1'b0}));
      chk(p2 === 3'b000, "R6 pwroff single cycle", 32'(p2), 0);
      rd(6, 0, 32'(v & 1), "R4 aux2 readback");
    end

    // R1 / R2: power-fail directed
    wr(6, 0, 0, p1, p2);
    wr(0, 0, 32'h08, p1, p2);
    set_pf(1'b1);
    chk(pwr_irq_o === 1'b1, "R2 status set, R1 irq", 32'(pwr_irq_o), 1);
    rd(6, 0, 32'h20, "R2 status visible");
    wr(6, 0, 32'h01, p1, p2);
    rd(6, 0, 32'h21, "R4 status kept");
    wr(6, 0, 32'h00, p1, p2);
    rd(6, 0, 32'h20, "R4 status kept 2");
    wr(0, 0, 32'h00, p1, p2);
    chk(pwr_irq_o === 1'b0, "R1 irq masked", 32'(pwr_irq_o), 0);
    rd(6, 0, 32'h20, "R1 status stays when masked");
    wr(0, 0, 32'h08, p1, p2);
    chk(pwr_irq_o === 1'b1, "R1 irq unmasked", 32'(pwr_irq_o), 1);
    wr(6, 0, 32'h03, p1, p2);
    rd(6, 0, 32'h01, "R5 clear keeps bit0");
    chk(pwr_irq_o === 1'b0, "R5 irq after clear", 32'(pwr_irq_o), 0);
    set_pf(1'b0);
    wr(0, 0, 32'h00, p1, p2);
    set_pf(1'b1);
    rd(6, 0, 32'h01, "R2 no set when disabled");
    wr(0, 0, 32'h08, p1, p2);
    rd(6, 0, 32'h01, "R2 steady input no set");
    set_pf(1'b0);
    set_pf(1'b1);
    rd(6, 0, 32'h21, "R2 set on rise");
    set_pf(1'b0);
    rd(6, 0, 32'h01, "R2 clear on fall");
    chk(pwr_irq_o === 1'b0, "R1 irq after fall", 32'(pwr_irq_o), 0);

    // R4 / R5: aux2 sweep with status set
    for (int v = 0; v < 256; v++) begin
      set_pf(1'b1);
      wr(6, 0, 32'(v), p1, p2);
      rd(6, 0, 32'((v & 1) | (v[1] ? 0 : 32'h20)), "R5 aux2 with status");
      chk(pwr_irq_o === !v[1], "R1 irq after aux2 write", 32'(pwr_irq_o), 32'(!v[1]));
      set_pf(1'b0);
    end

    // R7 / R10: system control
    wr(4, 0, 32'hFFFF_FFFF, p1, p2);
    chk(p1 === 3'b100 && p2 === 3'b000, "R7 reset pulse", 32'({p1, p2}), 32'h20);
    rd(4, 0, 32'h2, "R7 status readback");
    for (int o = 1; o < 4; o++) begin
      wr(4, 2'(o), 32'h1, p1, p2);
      chk({p1, p2} === 6'b0, "R7 other offset ignored", 32'({p1, p2}), 0);
      rd(4, 2'(o), 0, "R10 sysctl offset zero");
    end
    wr(4, 0, 32'h2, p1, p2);
    chk({p1, p2} === 6'b0, "R7 bit0 clear no request", 32'({p1, p2}), 0);
    rd(4, 0, 32'h2, "R7 unchanged");

    // R9 / R10: LED
    for (int k = 0; k < 64; k++) begin
      logic [15:0] lv;
      lv = 16'(k * 16'h0409 + 16'h1357);
      wr(3, 0, {16'hABCD, lv}, p1, p2);
      rd(3, 0, 32'(lv), "R9 LED readback");
      wr(3, 2'(1 + (k % 3)), 32'h0000_5AA5, p1, p2);
      rd(3, 0, 32'(lv), "R10 LED offset write ignored");
      rd(3, 2'(1 + (k % 3)), 0, "R10 LED offset read zero");
    end

    // R11: repeated reads
    wr(5, 0, 32'hF3, p1, p2);
    rd(5, 0, 32'hF1, "R11 read once");
    rd(5, 0, 32'hF1, "R11 read twice");

    // R8: selective reset
    wr(1, 0, 32'hA5, p1, p2);
    wr(0, 0, 32'h08, p1, p2);
    wr(2, 0, 32'h3C, p1, p2);
    wr(6, 0, 32'h01, p1, p2);
    wr(3, 0, 32'h0000_BEEF, p1, p2);
    do_reset();
    rd(0, 0, 0, "R8 cfg cleared");
    rd(2, 0, 0, "R8 modem cleared");
    rd(5, 0, 0, "R8 aux1 cleared");
    rd(6, 0, 0, "R8 aux2 cleared");
    rd(1, 0, 32'hA5, "R8 diag kept");
    rd(3, 0, 32'hBEEF, "R8 LED kept");
    rd(4, 0, 32'h2, "R8 sysctl kept");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule